// File: doc/BRIEF.md
# Channel Status and User Bit Capture

This block sits behind a digital audio interface receiver that has already recovered the biphase stream and identified the preambles. For every decoded subframe the receiver gives one strobe that carries the channel index, the channel-status bit, the user bit and a marker saying that the subframe opened a new 192-frame block. The block gathers both bit streams for the two audio channels into shadow images, one bit per frame. When the last subframe of a block arrives, it copies the complete images into the visible registers.

Software, or a neighbouring register block, reads the visible images as 32-bit words through a combinational read port keyed by byte address. Three kinds of single-cycle event pulse come out on an interrupt-event vector. One marks block start. One marks block end, meaning a complete image has been committed. The third is raised per channel, and only when that channel's newly committed status image differs from the one it replaces. A block cut short by a new start marker is dropped and never reaches the visible registers.

Top module: `chstat_capture`

## Requirements
- R1: While reset is held, and just after it is released, `irqEvents` is zero and every read address returns zero.
- R2: The visible words are at fixed byte addresses. Status word w of channel n (w = 0..5, n = 0..1) is at 0x30 + 0x30·n + 4·w. User word w of channel n is at 0x48 + 0x30·n + 4·w.
- R3: Any address outside 0x30..0x8F, or not a word address, reads as zero.
- R4: The bit of frame k sits in word k/32 at bit k mod 32. Seen as bytes, that is byte k/8 at bit k mod 8, with byte 0 in bits 7:0 of word 0 (little-endian).
- R5: A channel-1 subframe at frame index 191 completes a block, and the visible words update two clock edges later. `irqEvents[3]` is high for exactly the one cycle after that edge.
- R6: `irqEvents[8+n]` pulses in the same cycle as `irqEvents[3]`, but only when channel n's new 192-bit status image differs from the one previously visible. The image before the first block is all zeros.
- R7: A block whose status images match the visible ones updates the user words and raises no change pulse.
- R8: A valid channel-0 subframe carrying the start marker sets frame index 0. At the next edge it drives `irqEvents[11]` high for one cycle.
- R9: Subframes are ignored until the first start marker. After a completed block, they are ignored again until the next start marker.
- R10: A start marker that arrives before frame 191 restarts capture at frame 0. The cut-short block produces no block-end or change pulse and leaves the visible words unchanged.
- R11: A start marker on a channel-1 subframe has no effect beyond capturing that subframe's bits.
- R12: `irqEvents` bits other than 3, 8, 9 and 11 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| subValid | input | 1 | One decoded subframe present this cycle |
| subChan | input | 1 | Channel index of the subframe (0 or 1) |
| subC | input | 1 | Channel-status bit of the subframe |
| subU | input | 1 | User bit of the subframe |
| subBlockStart | input | 1 | Subframe opened a new block |
| rdAddr | input | 8 | Byte address of the word to read |
| rdData | output | 32 | Visible word at `rdAddr`, combinational |
| irqEvents | output | 16 | One-cycle event pulses: bit 3 block end, bits 8/9 status change, bit 11 block start |

## Verification
Two functions can land in the same cycle. One is the commit of a finished block. The other is the capture of the next block's first subframe, when blocks arrive back to back with no idle gap. In that case the block-end, change and block-start pulses all rise together. The bench sends two blocks with no idle gap between them. It checks that the committed words still hold the earlier block's frame-0 bits, which the new subframe overwrites in the shadow image in that same cycle. It also checks that the next block's change mask is computed against those committed words. A scoreboard queues one expected image set per completed block, and the monitor compares all 24 words and the change mask whenever a block-end pulse appears.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int NumCh       = 2;
  localparam int BlockFrames = 192;
  localparam int WordW       = 32;
  localparam int WordsPerImg = BlockFrames / WordW;
  localparam int ChW         = (NumCh > 1) ? $clog2(NumCh) : 1;
  localparam int FrameW      = $clog2(BlockFrames);
  localparam int AddrW       = 8;
  localparam int EvtW        = 16;

  // event bit positions decoded by the interrupt logic next door
  localparam int EvtBlockEnd   = 3;
  localparam int EvtChangeBase = 8;
  localparam int EvtBlockStart = 11;

  // address map (byte offsets)
  localparam int StatBase = 'h30;
  localparam int UserBase = 'h48;
  localparam int ChStride = 'h30;

  typedef struct packed {
    logic              wrEn;
    logic [ChW-1:0]    wrChan;
    logic [FrameW-1:0] wrIdx;
    logic              commit;
  } capStrobe_t;
endpackage

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import csu_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           subValid,
  input  logic [ChW-1:0] subChan,
  input  logic           subBlockStart,
  output capStrobe_t     strobe,
  output logic           startPulse
);
  localparam logic [FrameW-1:0] LastFrame = FrameW'(BlockFrames - 1);
  localparam logic [ChW-1:0]    LastChan  = ChW'(NumCh - 1);

  logic [FrameW-1:0] frameIdx;
  logic              armed;
  logic              commitQ;
  logic              isStart;
  logic              take;
  logic              lastCh;
  logic [FrameW-1:0] idxNow;

  always_comb begin
    isStart = subValid && subBlockStart && (subChan == '0);
    take    = subValid && (armed || isStart);
    lastCh  = (subChan == LastChan);
    idxNow  = isStart ? '0 : frameIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameIdx   <= '0;
      armed      <= 1'b0;
      commitQ    <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= isStart;
      commitQ    <= take && lastCh && (idxNow == LastFrame);
      if (isStart) begin
        armed    <= 1'b1;
        frameIdx <= '0;
      end else if (take && lastCh) begin
        if (frameIdx == LastFrame) begin
          frameIdx <= '0;
          armed    <= 1'b0;
        end else begin
          frameIdx <= frameIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.wrEn   = take;
    strobe.wrChan = subChan;
    strobe.wrIdx  = idxNow;
    strobe.commit = commitQ;
  end
endmodule

// File: rtl/csu_datapath.sv
module csu_datapath
  import csu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  input  logic             subC,
  input  logic             subU,
  input  logic [AddrW-1:0] rdAddr,
  output logic [WordW-1:0] rdData,
  output logic             endPulse,
  output logic [NumCh-1:0] chgPulse
);
  logic [NumCh-1:0][BlockFrames-1:0] shadowC, shadowU, visC, visU;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowC  <= '0;
      shadowU  <= '0;
      visC     <= '0;
      visU     <= '0;
      endPulse <= 1'b0;
      chgPulse <= '0;
    end else begin
      endPulse <= strobe.commit;
      if (strobe.wrEn) begin
        shadowC[strobe.wrChan][strobe.wrIdx] <= subC;
        shadowU[strobe.wrChan][strobe.wrIdx] <= subU;
      end
      if (strobe.commit) begin
        visC <= shadowC;
        visU <= shadowU;
      end
      for (int ch = 0; ch < NumCh; ch++) begin
        chgPulse[ch] <= strobe.commit && (shadowC[ch] != visC[ch]);
      end
    end
  end

  // word-addressed read of the visible images
  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NumCh; ch++) begin
      for (int w = 0; w < WordsPerImg; w++) begin
        if (rdAddr == AddrW'(StatBase + ch * ChStride + w * 4))
          rdData = visC[ch][w*WordW +: WordW];
        if (rdAddr == AddrW'(UserBase + ch * ChStride + w * 4))
          rdData = visU[ch][w*WordW +: WordW];
      end
    end
  end
endmodule

// File: rtl/chstat_capture.sv
module chstat_capture
  import csu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             subValid,
  input  logic [ChW-1:0]   subChan,
  input  logic             subC,
  input  logic             subU,
  input  logic             subBlockStart,
  input  logic [AddrW-1:0] rdAddr,
  output logic [WordW-1:0] rdData,
  output logic [EvtW-1:0]  irqEvents
);
  capStrobe_t       strobe;
  logic             startPulse;
  logic             endPulse;
  logic [NumCh-1:0] chgPulse;

  csu_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .subValid      (subValid),
    .subChan       (subChan),
    .subBlockStart (subBlockStart),
    .strobe        (strobe),
    .startPulse    (startPulse)
  );

  csu_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .subC     (subC),
    .subU     (subU),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .endPulse (endPulse),
    .chgPulse (chgPulse)
  );

  always_comb begin
    irqEvents = '0;
    irqEvents[EvtBlockEnd]   = endPulse;
    irqEvents[EvtBlockStart] = startPulse;
    for (int ch = 0; ch < NumCh; ch++) begin
      irqEvents[EvtChangeBase + ch] = chgPulse[ch];
    end
  end
endmodule

// File: rtl/chstat_capture_checker.sv
module chstat_capture_checker
  import csu_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             subValid,
  input logic [ChW-1:0]   subChan,
  input logic             subBlockStart,
  input logic [AddrW-1:0] rdAddr,
  input logic [WordW-1:0] rdData,
  input logic [EvtW-1:0]  irqEvents
);
  localparam logic [AddrW-1:0] LowEdge  = AddrW'(StatBase);
  localparam logic [AddrW-1:0] HighEdge = AddrW'(StatBase + NumCh * ChStride);

  logic [EvtW-1:0] usedMask;
  always_comb begin
    usedMask = '0;
    usedMask[EvtBlockEnd]   = 1'b1;
    usedMask[EvtBlockStart] = 1'b1;
    for (int ch = 0; ch < NumCh; ch++) usedMask[EvtChangeBase + ch] = 1'b1;
  end

  a_r5_end_single: assert property (@(posedge clk) disable iff (!rstN)
    irqEvents[EvtBlockEnd] |=> !irqEvents[EvtBlockEnd]);

  a_r6_change_with_end: assert property (@(posedge clk) disable iff (!rstN)
    (|irqEvents[EvtChangeBase +: NumCh]) |-> irqEvents[EvtBlockEnd]);

  a_r8_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqEvents[EvtBlockStart] |-> $past(subValid && subBlockStart && (subChan == '0)));

  a_r3_gap_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((rdAddr < LowEdge) || (rdAddr >= HighEdge) || (rdAddr[1:0] != 2'b00)) |-> (rdData == '0));

  a_r4_image_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((rdAddr == $past(rdAddr)) && !irqEvents[EvtBlockEnd]) |-> $stable(rdData));

  a_r12_unused_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((irqEvents & ~usedMask) == '0));
endmodule

bind chstat_capture chstat_capture_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .subValid      (subValid),
  .subChan       (subChan),
  .subBlockStart (subBlockStart),
  .rdAddr        (rdAddr),
  .rdData        (rdData),
  .irqEvents     (irqEvents)
);

// File: tb/chstat_capture_tb.sv
`timescale 1ns/10ps
module chstat_capture_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        subValid = 1'b0;
  logic [0:0]  subChan = '0;
  logic        subC = 1'b0;
  logic        subU = 1'b0;
  logic        subBlockStart = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [15:0] irqEvents;

  chstat_capture u_dut (
    .clk(clk), .rstN(rstN), .subValid(subValid), .subChan(subChan),
    .subC(subC), .subU(subU), .subBlockStart(subBlockStart),
    .rdAddr(rdAddr), .rdData(rdData), .irqEvents(irqEvents)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]   chg;
    logic [191:0] s0, s1, u0, u1;
  } expItem_t;

  expItem_t     expQ[$];
  logic [191:0] mS0 = '0, mS1 = '0;
  int checks = 0, errors = 0;
  int endSeen = 0, startSeen = 0, startExp = 0;
  bit monEn = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    subValid = 0; subBlockStart = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sub(input int ch, input bit c, input bit u, input bit st);
    subValid = 1; subChan = ch[0]; subC = c; subU = u; subBlockStart = st;
    @(negedge clk);
  endtask

  // drive nFrames frames; a complete started block pushes its expectation
  task automatic sendBlock(input logic [191:0] s0, s1, u0, u1,
                           input int nFrames, input bit withStart, input int ch1StartAt,
                           input bit expectEnd);
    expItem_t it;
    if (expectEnd) begin
      it.chg = {s1 != mS1, s0 != mS0};
      it.s0 = s0; it.s1 = s1; it.u0 = u0; it.u1 = u1;
      mS0 = s0; mS1 = s1;
      expQ.push_back(it);
    end
    if (withStart) startExp++;
    for (int k = 0; k < nFrames; k++) begin
      sub(0, s0[k], u0[k], withStart && (k == 0));
      sub(1, s1[k], u1[k], k == ch1StartAt);
    end
    subValid = 0; subBlockStart = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    rdAddr = a; #0.05;
    chk(rdData === exp, req, rdData, exp);
  endtask

  // monitor: pops one expectation per block-end pulse and compares all words
  initial begin
    wait (monEn);
    forever begin
      @(negedge clk);
      if (irqEvents != 0)
        chk((irqEvents & ~16'h0B08) == 0, "R12", {16'h0, irqEvents}, {16'h0, irqEvents & 16'h0B08});
      if (irqEvents[11]) startSeen++;
      if (irqEvents[3]) begin
        endSeen++;
        if (expQ.size() == 0) begin
          chk(0, "R9/R10 unexpected block end", 32'd1, 32'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(irqEvents[9:8] == it.chg, "R6 change mask", {30'h0, irqEvents[9:8]}, {30'h0, it.chg});
          for (int w = 0; w < 6; w++) begin
            rd(8'(8'h30 + w*4), it.s0[w*32 +: 32], "R2/R4 ch0 status");
            rd(8'(8'h48 + w*4), it.u0[w*32 +: 32], "R2/R4 ch0 user");
            rd(8'(8'h60 + w*4), it.s1[w*32 +: 32], "R2/R4 ch1 status");
            rd(8'(8'h78 + w*4), it.u1[w*32 +: 32], "R2/R4 ch1 user");
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    logic [191:0] pA, pB, pC, uA, uB, walk;
    pA = {6{32'hA5C3_0F01}};
    pB = {6{32'h5A3C_F0FE}};
    pC = {6{32'h0000_8001}};
    uA = {6{32'h1234_5678}};
    uB = {6{32'hFEDC_BA98}};
    walk = '0; walk[37] = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(irqEvents == 0, "R1 events in reset", {16'h0, irqEvents}, 32'h0);
    rd(8'h30, 32'h0, "R1 reset read");
    rd(8'h8C, 32'h0, "R1 reset read");
    rstN = 1;
    @(negedge clk);
    chk(irqEvents == 0, "R1 events after reset", {16'h0, irqEvents}, 32'h0);
    monEn = 1;

    // R9: traffic before any start marker is ignored
    sendBlock(pA, pA, uA, uA, 10, 0, -1, 0);
    idle(5);
    chk(endSeen == 0 && startSeen == 0, "R9 pre-start ignored", endSeen, 0);
    rd(8'h30, 32'h0, "R9 pre-start words unchanged");

    // R4/R5/R6: first block, single bit at frame 37 on ch0
    sendBlock(walk, pA, uA, uB, 192, 1, -1, 1);
    idle(5);
    rd(8'h34, 32'h0000_0020, "R4 frame 37 -> word1 bit5");
    chk(endSeen == 1, "R5 block end count", endSeen, 1);

    // R7: same status, new user bits
    sendBlock(walk, pA, uB, uA, 192, 1, -1, 1);
    idle(5);
    rd(8'h48, uB[31:0], "R7 user updated");

    // R6: only ch1 status changes
    sendBlock(walk, pB, uB, uA, 192, 1, -1, 1);
    idle(5);

    // back to back: commit coincides with next block's first subframe
    sendBlock(pC, pB, uA, uA, 192, 1, -1, 1);
    sendBlock(pA, pB, uB, uB, 192, 1, -1, 1);
    idle(5);
    chk(endSeen == 5, "R5 back-to-back ends", endSeen, 5);

    // R9: full block without start after completion is ignored
    sendBlock(pB, pA, uA, uA, 192, 0, -1, 0);
    idle(5);
    chk(endSeen == 5, "R9 unstarted block ignored", endSeen, 5);
    rd(8'h30, pA[31:0], "R9 words unchanged");

    // R10: early start discards partial block
    sendBlock(pC, pC, uA, uA, 100, 1, -1, 0);
    rd(8'h60, pB[31:0], "R10 partial not visible");
    sendBlock(pB, pA, uA, uB, 192, 1, -1, 1);
    idle(5);
    chk(endSeen == 6, "R10 one end for cut block pair", endSeen, 6);

    // R11: start marker on ch1 in mid block has no effect
    sendBlock(pA, pC, uB, uA, 192, 1, 50, 1);
    idle(5);
    chk(endSeen == 7, "R11 block completes", endSeen, 7);

    // R3: unmapped addresses
    rd(8'h00, 32'h0, "R3 below map");
    rd(8'h2C, 32'h0, "R3 below map");
    rd(8'h90, 32'h0, "R3 above map");
    rd(8'hFC, 32'h0, "R3 above map");
    rd(8'h31, 32'h0, "R3 unaligned");

    chk(expQ.size() == 0, "R5 all blocks ended", expQ.size(), 0);
    chk(startSeen == startExp, "R8 start pulses", startSeen, startExp);
    finishRun();
  end
endmodule